// File: doc/BRIEF.md
# ECC Error Capture and Status Registers

This block sits beside the error-correction checker of a two-channel DRAM controller. It records which kinds of ECC error have happened and logs the details of one error on each channel. In any cycle the checker can present one error event per channel. An event is marked correctable or uncorrectable and carries the rank, bank, row, column and syndrome of the failing access. A global status register gathers a correctable flag and an uncorrectable flag. Software clears each flag by writing a 1 to it.

Each channel keeps a 64-bit log of one captured error. An uncorrectable error always replaces a logged correctable one. Because of this, software that reads the status register, then the logs, then the status again can see the contents change between its reads. A single-channel mode input shuts off every channel above channel 0. For each channel the block also drives a flat rank index, built from the channel number and the logged rank.

Registers are read through a valid/address port with one cycle of latency. Each log is read as two 32-bit words. Writes reach only the status register.

Top module: `ecc_errlog_regs`

## Requirements
- R1: Reading word address 0 returns the status register zero-extended to 32 bits. Bit 0 is the correctable flag, bit 1 is the uncorrectable flag, and bits 31:2 read as zero.
- R2: A write to address 0 with clear-mask bit 0 set clears the correctable flag, and with bit 1 set clears the uncorrectable flag. A mask bit of 0 leaves its flag unchanged.
- R3: The log of channel c is read as its low word at address 2+2c and its high word at address 3+2c. The 64-bit layout is: column in 63:48, row in 47:32, bank in 31:29, rank in 28:27, syndrome in 23:16, uncorrectable status in bit 1 and correctable status in bit 0. Bits 26:24 and 15:2 read as zero.
- R4: A correctable event is logged only when neither status bit of that channel's log is set. A later correctable event leaves the log unchanged.
- R5: An uncorrectable event on a channel whose log has no uncorrectable status overwrites every field. It records the syndrome as zero, sets bit 1 and keeps bit 0 as it was.
- R6: A log that holds an uncorrectable error is not changed by any later event until bit 1 is cleared.
- R7: Clearing a status flag also clears the matching status bit in every channel log. A log with both bits cleared captures the next event; its fields stay until then.
- R8: If an event and a clear of the same flag happen in the same cycle, the flag stays set and the log captures the new event.
- R9: While single-channel mode is high, events on channel 1 change neither its log nor the status flags.
- R10: The rank index output of channel c equals c*4 plus the logged 2-bit rank.
- R11: A read request is answered one cycle later with the read-valid output high for exactly one cycle. Unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| single_chan_i | input | 1 | High selects single-channel mode |
| evt_vld_i | input | 2 | Error event valid, one bit per channel |
| evt_ue_i | input | 2 | 1 = uncorrectable, 0 = correctable, per channel |
| evt_rank_i | input | 4 | Rank of the event, 2 bits per channel |
| evt_bank_i | input | 6 | Bank, 3 bits per channel |
| evt_row_i | input | 32 | Row, 16 bits per channel |
| evt_col_i | input | 32 | Column, 16 bits per channel |
| evt_synd_i | input | 16 | Syndrome, 8 bits per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address (0 = status) |
| wr_data_i | input | 2 | Clear mask for the status flags |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| rank_idx_o | output | 6 | Flat rank index, 3 bits per channel |

## Verification
The bench sends an uncorrectable error onto a logged correctable one. A design that did not let it overwrite would keep the stale correctable fields, and one that kept the syndrome would show a nonzero syndrome. The bench also sends late correctable and uncorrectable errors after the first capture. A design without first-capture priority would lose the original error. A clear that lands in the same cycle as a new event shows whether the clear wrongly wins. Channel 1 events in single-channel mode would leak into the status flags. The bench checks that a clear re-arms capture and that rank indices are offset per channel. A log that did not re-arm would drop the next error, and missing offsets would alias the two channels' ranks.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;
  localparam int unsigned RANK_W = 2;
  localparam int unsigned BANK_W = 3;
  localparam int unsigned ROW_W  = 16;
  localparam int unsigned COL_W  = 16;
  localparam int unsigned SYND_W = 8;
  localparam int unsigned LOG_W  = 64;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic              ue;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [SYND_W-1:0] synd;
  } ecc_evt_t;

  // Assemble the 64-bit log word from its fields.
  function automatic logic [LOG_W-1:0] pack_log(
    input logic              ue,
    input logic              ce,
    input logic [RANK_W-1:0] rank,
    input logic [BANK_W-1:0] bank,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col,
    input logic [SYND_W-1:0] synd
  );
    return {col, row, bank, rank, 3'b000, synd, 14'b0, ue, ce};
  endfunction
endpackage

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_errlog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             evt_vld_i,
  input  ecc_evt_t         evt_i,
  input  logic             clr_ce_i,
  input  logic             clr_ue_i,
  output logic [LOG_W-1:0] log_o,
  output logic [RANK_W-1:0] rank_o,
  output logic             acc_ce_o,
  output logic             acc_ue_o
);
  logic              ce_q, ue_q, ce_d, ue_d;
  logic              ce_kept, ue_kept;
  logic              take_ce, take_ue, fld_ld;
  logic [RANK_W-1:0] rank_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [SYND_W-1:0] synd_q, synd_d;

  always_comb begin
    acc_ce_o = evt_vld_i & en_i & ~evt_i.ue;
    acc_ue_o = evt_vld_i & en_i &  evt_i.ue;
    ce_kept  = ce_q & ~clr_ce_i;
    ue_kept  = ue_q & ~clr_ue_i;
    // capture eligibility is judged after this cycle's clear
    take_ce  = acc_ce_o & ~ce_kept & ~ue_kept;
    take_ue  = acc_ue_o & ~ue_kept;
    fld_ld   = take_ce | take_ue;
    ce_d     = ce_kept | take_ce;
    ue_d     = ue_kept | take_ue;
    synd_d   = take_ue ? '0 : evt_i.synd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      ue_q   <= 1'b0;
      rank_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      synd_q <= '0;
    end else begin
      ce_q <= ce_d;
      ue_q <= ue_d;
      if (fld_ld) begin
        rank_q <= evt_i.rank;
        bank_q <= evt_i.bank;
        row_q  <= evt_i.row;
        col_q  <= evt_i.col;
        synd_q <= synd_d;
      end
    end
  end

  assign log_o  = pack_log(ue_q, ce_q, rank_q, bank_q, row_q, col_q, synd_q);
  assign rank_o = rank_q;
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_errlog_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    acc_ce_i,
  input  logic [NCH-1:0]    acc_ue_i,
  input  logic              clr_ce_i,
  input  logic              clr_ue_i,
  output logic [STAT_W-1:0] status_o
);
  logic ce_q, ue_q, ce_d, ue_d;

  always_comb begin
    ce_d = (ce_q & ~clr_ce_i) | (|acc_ce_i);
    ue_d = (ue_q & ~clr_ue_i) | (|acc_ue_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      ue_q <= 1'b0;
    end else begin
      ce_q <= ce_d;
      ue_q <= ue_d;
    end
  end

  assign status_o = {{(STAT_W-2){1'b0}}, ue_q, ce_q};
endmodule

// File: rtl/ecc_reg_rdmux.sv
module ecc_reg_rdmux
  import ecc_errlog_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned AW       = 3,
  parameter int unsigned LOG_BASE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            rd_addr_i,
  input  logic [STAT_W-1:0]        status_i,
  input  logic [NCH-1:0][LOG_W-1:0] logs_i,
  output logic [WORD_W-1:0]        rd_data_o,
  output logic                     rd_valid_o
);
  logic [WORD_W-1:0] data_d, data_q;
  logic              vld_q;

  always_comb begin
    data_d = '0;
    if (rd_addr_i == '0) data_d = {{(WORD_W-STAT_W){1'b0}}, status_i};
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr_i == AW'(LOG_BASE + 2*c))     data_d = logs_i[c][WORD_W-1:0];
      if (rd_addr_i == AW'(LOG_BASE + 2*c + 1)) data_d = logs_i[c][LOG_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      if (rd_en_i) data_q <= data_d;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = vld_q;
endmodule

// File: rtl/ecc_errlog_regs.sv
module ecc_errlog_regs
  import ecc_errlog_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned AW   = 3,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned RI_W = CH_W + RANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  single_chan_i,
  input  logic [NCH-1:0]        evt_vld_i,
  input  logic [NCH-1:0]        evt_ue_i,
  input  logic [NCH*RANK_W-1:0] evt_rank_i,
  input  logic [NCH*BANK_W-1:0] evt_bank_i,
  input  logic [NCH*ROW_W-1:0]  evt_row_i,
  input  logic [NCH*COL_W-1:0]  evt_col_i,
  input  logic [NCH*SYND_W-1:0] evt_synd_i,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [1:0]            wr_data_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [WORD_W-1:0]     rd_data_o,
  output logic                  rd_valid_o,
  output logic [NCH*RI_W-1:0]   rank_idx_o
);
  logic                      rst_s1_q, rst_sync_n;
  logic                      wr_hit, clr_ce, clr_ue;
  logic [NCH-1:0]            acc_ce, acc_ue;
  logic [NCH-1:0][LOG_W-1:0] log_w;
  logic [STAT_W-1:0]         status_w;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  always_comb begin
    wr_hit = wr_en_i & (wr_addr_i == '0);
    clr_ce = wr_hit & wr_data_i[0];
    clr_ue = wr_hit & wr_data_i[1];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ecc_evt_t          evt;
    logic              en;
    logic [RANK_W-1:0] rank;
    assign evt.ue   = evt_ue_i[c];
    assign evt.rank = evt_rank_i[c*RANK_W +: RANK_W];
    assign evt.bank = evt_bank_i[c*BANK_W +: BANK_W];
    assign evt.row  = evt_row_i[c*ROW_W +: ROW_W];
    assign evt.col  = evt_col_i[c*COL_W +: COL_W];
    assign evt.synd = evt_synd_i[c*SYND_W +: SYND_W];
    if (c == 0) begin : g_prim
      assign en = 1'b1;
    end else begin : g_sec
      assign en = ~single_chan_i;
    end

    ecc_chan_log u_log (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en_i     (en),
      .evt_vld_i(evt_vld_i[c]),
      .evt_i    (evt),
      .clr_ce_i (clr_ce),
      .clr_ue_i (clr_ue),
      .log_o    (log_w[c]),
      .rank_o   (rank),
      .acc_ce_o (acc_ce[c]),
      .acc_ue_o (acc_ue[c])
    );
    assign rank_idx_o[c*RI_W +: RI_W] = {CH_W'(c), rank};
  end

  ecc_err_status #(.NCH(NCH)) u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc_ce_i(acc_ce),
    .acc_ue_i(acc_ue),
    .clr_ce_i(clr_ce),
    .clr_ue_i(clr_ue),
    .status_o(status_w)
  );

  ecc_reg_rdmux #(.NCH(NCH), .AW(AW)) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .status_i  (status_w),
    .logs_i    (log_w),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );
endmodule

// File: rtl/ecc_errlog_chk.sv
module ecc_errlog_chk
  import ecc_errlog_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      single_chan_i,
  input logic [NCH-1:0]            evt_vld_i,
  input logic [NCH-1:0]            evt_ue_i,
  input logic                      wr_en_i,
  input logic [AW-1:0]             wr_addr_i,
  input logic [1:0]                wr_data_i,
  input logic                      rd_en_i,
  input logic [AW-1:0]             rd_addr_i,
  input logic [WORD_W-1:0]         rd_data_o,
  input logic                      rd_valid_o,
  input logic [STAT_W-1:0]         status_w,
  input logic [NCH-1:0][LOG_W-1:0] log_w
);
  logic clr_ce, clr_ue;
  assign clr_ce = wr_en_i && (wr_addr_i == '0) && wr_data_i[0];
  assign clr_ue = wr_en_i && (wr_addr_i == '0) && wr_data_i[1];

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
  // R1
  status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == '0) |=> (rd_data_o[WORD_W-1:2] == '0));
  // R9
  single_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_chan_i && !clr_ce && !clr_ue) |=> $stable(log_w[NCH-1]));
  // R6
  ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_w[0][1] && !clr_ue) |=> (log_w[0][1] && $stable(log_w[0][LOG_W-1:2])));
  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && evt_vld_i[0] && !evt_ue_i[0]) |=> status_w[0]);
  // R2
  ue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && evt_vld_i == '0) |=> !status_w[1]);
endmodule

bind ecc_errlog_regs ecc_errlog_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .single_chan_i(single_chan_i),
  .evt_vld_i    (evt_vld_i),
  .evt_ue_i     (evt_ue_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .status_w     (status_w),
  .log_w        (log_w)
);

// File: tb/ecc_errlog_regs_bench.sv
module ecc_errlog_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, single_chan;
  logic [1:0]  evt_vld, evt_ue;
  logic [3:0]  evt_rank;
  logic [5:0]  evt_bank;
  logic [31:0] evt_row, evt_col;
  logic [15:0] evt_synd;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [1:0]  wr_data;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [5:0]  rank_idx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_errlog_regs u_ecc_errlog_regs (
    .clk(clk), .rst_n(rst_n), .single_chan_i(single_chan),
    .evt_vld_i(evt_vld), .evt_ue_i(evt_ue), .evt_rank_i(evt_rank),
    .evt_bank_i(evt_bank), .evt_row_i(evt_row), .evt_col_i(evt_col),
    .evt_synd_i(evt_synd), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rank_idx_o(rank_idx)
  );

  function automatic logic [63:0] mk(input logic ue, input logic ce, input logic [1:0] rk,
    input logic [2:0] bk, input logic [15:0] rw, input logic [15:0] cl, input logic [7:0] sy);
    return {cl, rw, bk, rk, 3'b000, sy, 14'b0, ue, ce};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rd_log(input int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'(2 + 2*ch), lo);
    rd(3'(3 + 2*ch), hi);
    v = {hi, lo};
  endtask

  task automatic set_evt(input int ch, input logic ue, input logic [1:0] rk, input logic [2:0] bk,
    input logic [15:0] rw, input logic [15:0] cl, input logic [7:0] sy);
    evt_vld[ch] = 1'b1; evt_ue[ch] = ue;
    evt_rank[ch*2 +: 2] = rk; evt_bank[ch*3 +: 3] = bk;
    evt_row[ch*16 +: 16] = rw; evt_col[ch*16 +: 16] = cl; evt_synd[ch*8 +: 8] = sy;
  endtask

  task automatic send(input int ch, input logic ue, input logic [1:0] rk, input logic [2:0] bk,
    input logic [15:0] rw, input logic [15:0] cl, input logic [7:0] sy);
    @(negedge clk); set_evt(ch, ue, rk, bk, rw, cl, sy);
    @(negedge clk); evt_vld = '0;
  endtask

  task automatic wr_clr(input logic [1:0] m);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = m;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] s; logic [63:0] l;
    rd(3'd0, s);    chk("R1 reset status", 64'(s), 64'h0);
    rd_log(0, l);   chk("R3 reset log0", l, 64'h0);
    rd_log(1, l);   chk("R3 reset log1", l, 64'h0);
    chk("R10 reset rank idx", 64'(rank_idx), 64'({3'd4, 3'd0}));
  endtask

  task automatic t_first_ce;
    logic [31:0] s; logic [63:0] l;
    send(0, 1'b0, 2'd2, 3'd5, 16'h1234, 16'hABCD, 8'h5A);
    rd(3'd0, s);  chk("R1 CE flag", 64'(s), 64'h1);
    rd_log(0, l); chk("R3 CE log layout", l, mk(0, 1, 2'd2, 3'd5, 16'h1234, 16'hABCD, 8'h5A));
    chk("R10 ch0 rank idx", 64'(rank_idx[2:0]), 64'd2);
    send(0, 1'b0, 2'd1, 3'd1, 16'h0001, 16'h0002, 8'h33);
    rd_log(0, l); chk("R4 second CE ignored", l, mk(0, 1, 2'd2, 3'd5, 16'h1234, 16'hABCD, 8'h5A));
  endtask

  task automatic t_ue_over;
    logic [31:0] s; logic [63:0] l;
    send(0, 1'b1, 2'd3, 3'd7, 16'hBEEF, 16'h0F0F, 8'h99);
    rd(3'd0, s);  chk("R5 both flags", 64'(s), 64'h3);
    rd_log(0, l); chk("R5 UE overwrite", l, mk(1, 1, 2'd3, 3'd7, 16'hBEEF, 16'h0F0F, 8'h00));
    send(0, 1'b1, 2'd0, 3'd2, 16'h1111, 16'h2222, 8'h44);
    send(0, 1'b0, 2'd1, 3'd3, 16'h3333, 16'h4444, 8'h55);
    rd_log(0, l); chk("R6 UE log kept", l, mk(1, 1, 2'd3, 3'd7, 16'hBEEF, 16'h0F0F, 8'h00));
  endtask

  task automatic t_clear;
    logic [31:0] s; logic [63:0] l;
    wr_clr(2'b00);
    rd(3'd0, s);  chk("R2 zero write no effect", 64'(s), 64'h3);
    wr_clr(2'b01);
    rd(3'd0, s);  chk("R2 clear CE flag", 64'(s), 64'h2);
    rd_log(0, l); chk("R7 log CE bit cleared", l, mk(1, 0, 2'd3, 3'd7, 16'hBEEF, 16'h0F0F, 8'h00));
    wr_clr(2'b10);
    rd(3'd0, s);  chk("R2 clear UE flag", 64'(s), 64'h0);
    rd_log(0, l); chk("R7 log bits cleared fields kept", l, mk(0, 0, 2'd3, 3'd7, 16'hBEEF, 16'h0F0F, 8'h00));
    send(0, 1'b0, 2'd1, 3'd4, 16'h0A0A, 16'h0B0B, 8'hC3);
    rd_log(0, l); chk("R7 re-armed capture", l, mk(0, 1, 2'd1, 3'd4, 16'h0A0A, 16'h0B0B, 8'hC3));
  endtask

  task automatic t_same_cycle;
    logic [31:0] s; logic [63:0] l;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 2'b01;
    set_evt(0, 1'b0, 2'd3, 3'd1, 16'h5555, 16'h6666, 8'h77);
    @(negedge clk); wr_en = 1'b0; evt_vld = '0;
    rd(3'd0, s);  chk("R8 flag stays set", 64'(s), 64'h1);
    rd_log(0, l); chk("R8 new event logged", l, mk(0, 1, 2'd3, 3'd1, 16'h5555, 16'h6666, 8'h77));
  endtask

  task automatic t_chan1;
    logic [31:0] s; logic [63:0] l;
    wr_clr(2'b11);
    send(1, 1'b0, 2'd1, 3'd6, 16'hC0DE, 16'hF00D, 8'hE1);
    rd_log(1, l); chk("R3 ch1 log", l, mk(0, 1, 2'd1, 3'd6, 16'hC0DE, 16'hF00D, 8'hE1));
    chk("R10 ch1 rank idx", 64'(rank_idx[5:3]), 64'd5);
    rd(3'd0, s);  chk("R1 ch1 CE flag", 64'(s), 64'h1);
  endtask

  task automatic t_single;
    logic [31:0] s; logic [63:0] l;
    wr_clr(2'b11);
    single_chan = 1'b1;
    send(1, 1'b1, 2'd2, 3'd2, 16'h9999, 16'h8888, 8'h12);
    send(1, 1'b0, 2'd3, 3'd3, 16'h7777, 16'h6666, 8'h34);
    rd(3'd0, s);  chk("R9 status untouched", 64'(s), 64'h0);
    rd_log(1, l); chk("R9 ch1 log frozen", l, mk(0, 0, 2'd1, 3'd6, 16'hC0DE, 16'hF00D, 8'hE1));
    single_chan = 1'b0;
  endtask

  task automatic t_read_port;
    logic [31:0] d;
    @(negedge clk); rd_en = 1'b1; rd_addr = 3'd6;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 valid one cycle later", 64'(rd_valid), 64'h1);
    chk("R11 unmapped 6 zero", 64'(rd_data), 64'h0);
    @(negedge clk);
    chk("R11 valid drops", 64'(rd_valid), 64'h0);
    rd(3'd1, d); chk("R11 unmapped 1 zero", 64'(d), 64'h0);
    rd(3'd7, d); chk("R11 unmapped 7 zero", 64'(d), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; single_chan = 1'b0; evt_vld = '0; evt_ue = '0;
    evt_rank = '0; evt_bank = '0; evt_row = '0; evt_col = '0; evt_synd = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_ce();
    t_ue_over();
    t_clear();
    t_same_cycle();
    t_chan1();
    t_single();
    t_read_port();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule